// File: doc/BRIEF.md
# Register-Programmed Clock Divider

This block divides its input clock by a ratio held in a bit field of a 32-bit control register. Software writes the register through a single-cycle write port and can read it back at any time. The field sits at a parameterised bit offset and has a parameterised width. A build-time parameter chooses how the field value is turned into a divisor. The choices are: value plus one; the raw value, where zero is either invalid or a bypass; two raised to the value; or the raw value with zero standing for the largest ratio.

The divided clock appears in two forms. The first is a one-cycle enable pulse, `tickOut`, in the last input cycle of every output period. The second is a square wave, `clkOut`, which is high for the first half of each period. A new ratio takes effect only when the current output period has finished, so no period is ever cut short.

Two build-time options change how writes behave. In masked mode, the upper half-word of each write is a per-bit enable for the lower half-word, and only the lower half-word is stored. In read-only mode, writes are discarded and the register keeps its reset value.

Top module: `clk_ratio_divider`

## Requirements
- R1: After reset the register reads 0, and the divider runs at the ratio that a field of zero decodes to in the selected mode (zero-based: 1; max-at-zero with a 4-bit field: 16).
- R2: In zero-based decoding (DECODE = DEC_ZERO_BASED) the divisor is the field value plus one.
- R3: In one-based decoding without bypass, the divisor is the field value. A field of zero raises `errOut` for as long as the field stays zero, and the divider keeps the last valid divisor. The fallback after reset is 1. `errOut` stays low in every other mode.
- R4: In one-based decoding with ALLOW_ZERO = 1, a field of zero gives divide-by-one: `tickOut` is high every cycle and `errOut` stays low.
- R5: In power-of-two decoding the divisor is 2 raised to the field value.
- R6: In max-at-zero decoding the divisor is the field value, except that zero selects 2^FIELD_WIDTH.
- R7: The field is bits [FIELD_SHIFT +: FIELD_WIDTH]. Bits outside the field do not affect the ratio. In plain write mode all 32 written bits are stored and read back unchanged, and the register does not change in a cycle without `wrEn`.
- R8: In masked mode, stored bit i (0 to 15) takes data bit i only when data bit 16+i is set; otherwise it keeps its value. Bits 31:16 read back as 0.
- R9: In read-only mode, writes change neither the readback (always 0) nor the ratio.
- R10: A new ratio is applied only at the end of the period in progress. That period completes with the old length, and the next period has the new length.
- R11: For a divisor D, `clkOut` is high for floor(D/2) cycles and then low for the rest of the period. `tickOut` is high in the last cycle of the period and never together with `clkOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rstN | input | 1 | Synchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 32 | Register write data (upper half is the write mask in masked mode) |
| rdData | output | 32 | Register readback |
| tickOut | output | 1 | One-cycle enable at the end of each output period |
| clkOut | output | 1 | Divided square wave, high in the first half of the period |
| errOut | output | 1 | Field holds an invalid zero (one-based decoding without bypass) |

## Verification
If the stored ratio or the decoder is wrong, the result shows up at the ports within one output period. The gap between two `tickOut` pulses would have the wrong length, or the high time of `clkOut` would be wrong. A wrong reload point shows as a single period, the one in progress during the write, that has neither the old length nor the new one. Errors in register storage, masking or read-only handling appear in `rdData` on the cycle after the write.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

  typedef enum logic [1:0] {
    DEC_ZERO_BASED,
    DEC_ONE_BASED,
    DEC_POW2,
    DEC_MAX_AT_ZERO
  } decode_e;

  // Strobes from the register/decode control into the counting datapath
  typedef struct packed {
    logic ratioChange;   // decoded divisor differs from the one seen last cycle
  } cdiv_strobes_t;

  // Counter width large enough for the biggest divisor a mode can produce
  function automatic int cntWidth(decode_e mode, int fieldWidth);
    if (mode == DEC_POW2) return (1 << fieldWidth);
    return fieldWidth + 1;
  endfunction

endpackage

// File: rtl/cdiv_ctrl.sv
module cdiv_ctrl
  import cdiv_pkg::*;
#(
  parameter decode_e DECODE       = DEC_ZERO_BASED,
  parameter bit      ALLOW_ZERO   = 1'b0,
  parameter bit      MASKED_WRITE = 1'b0,
  parameter bit      READ_ONLY    = 1'b0,
  parameter int      FIELD_SHIFT  = 4,
  parameter int      FIELD_WIDTH  = 4,
  parameter int      CNT_W        = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [31:0]         wrData,
  output logic [31:0]         rdData,
  output logic                errOut,
  output logic [CNT_W-1:0]    pendDiv,
  output cdiv_strobes_t       strb
);

  localparam int HALF_W = 16;

  logic [31:0]            ctrlReg;
  logic [31:0]            nextReg;
  logic                   wrAccept;
  logic [FIELD_WIDTH-1:0] field;
  logic [CNT_W-1:0]       decDiv;
  logic                   zeroInvalid;
  logic                   decBad;
  logic [CNT_W-1:0]       lastValidDiv;

  // ---------------- register write path ----------------
  assign wrAccept = wrEn && !READ_ONLY;

  generate
    if (MASKED_WRITE) begin : g_masked
      logic [HALF_W-1:0] bitEn;
      assign bitEn   = wrData[31:HALF_W];
      assign nextReg = {{HALF_W{1'b0}},
                        (ctrlReg[HALF_W-1:0] & ~bitEn) | (wrData[HALF_W-1:0] & bitEn)};
    end else begin : g_plain
      assign nextReg = wrData;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)         ctrlReg <= '0;
    else if (wrAccept) ctrlReg <= nextReg;
  end

  assign rdData = ctrlReg;
  assign field  = ctrlReg[FIELD_SHIFT +: FIELD_WIDTH];

  // ---------------- field decode ----------------
  generate
    if (DECODE == DEC_ZERO_BASED) begin : g_zero
      assign decDiv      = CNT_W'(field) + CNT_W'(1);
      assign zeroInvalid = 1'b0;
    end else if (DECODE == DEC_ONE_BASED) begin : g_one
      assign decDiv      = (field == '0) ? CNT_W'(1) : CNT_W'(field);
      assign zeroInvalid = (field == '0);
    end else if (DECODE == DEC_POW2) begin : g_pow
      assign decDiv      = CNT_W'(1) << field;
      assign zeroInvalid = 1'b0;
    end else begin : g_maxz
      assign decDiv      = (field == '0) ? (CNT_W'(1) << FIELD_WIDTH) : CNT_W'(field);
      assign zeroInvalid = 1'b0;
    end
  endgenerate

  // A zero that is not a bypass is rejected; hold the previous divisor
  assign decBad  = zeroInvalid && !ALLOW_ZERO;
  assign pendDiv = decBad ? lastValidDiv : decDiv;
  assign errOut  = decBad;

  always_ff @(posedge clk) begin
    if (!rstN) lastValidDiv <= decBad ? CNT_W'(1) : decDiv;
    else       lastValidDiv <= pendDiv;
  end

  assign strb.ratioChange = (pendDiv != lastValidDiv);

endmodule

// File: rtl/cdiv_datapath.sv
module cdiv_datapath
  import cdiv_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] pendDiv,
  input  cdiv_strobes_t    strb,
  output logic             tickOut,
  output logic             clkOut
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] activeDiv;
  logic             armed;
  logic             periodEnd;

  assign periodEnd = (cnt == activeDiv - CNT_W'(1));

  // The ratio is swapped only on the wrap of the counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt       <= '0;
      activeDiv <= pendDiv;
      armed     <= 1'b0;
    end else if (periodEnd) begin
      cnt   <= '0;
      armed <= 1'b0;
      if (armed || strb.ratioChange) activeDiv <= pendDiv;
    end else begin
      cnt <= cnt + CNT_W'(1);
      if (strb.ratioChange) armed <= 1'b1;
    end
  end

  assign tickOut = periodEnd;
  assign clkOut  = (cnt < (activeDiv >> 1));

endmodule

// File: rtl/clk_ratio_divider.sv
module clk_ratio_divider
  import cdiv_pkg::*;
#(
  parameter decode_e DECODE       = DEC_ZERO_BASED,
  parameter bit      ALLOW_ZERO   = 1'b0,
  parameter bit      MASKED_WRITE = 1'b0,
  parameter bit      READ_ONLY    = 1'b0,
  parameter int      FIELD_SHIFT  = 4,
  parameter int      FIELD_WIDTH  = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        tickOut,
  output logic        clkOut,
  output logic        errOut
);

  localparam int CNT_W = cntWidth(DECODE, FIELD_WIDTH);

  logic [CNT_W-1:0] pendDiv;
  cdiv_strobes_t    strb;

  cdiv_ctrl #(
    .DECODE(DECODE), .ALLOW_ZERO(ALLOW_ZERO), .MASKED_WRITE(MASKED_WRITE),
    .READ_ONLY(READ_ONLY), .FIELD_SHIFT(FIELD_SHIFT), .FIELD_WIDTH(FIELD_WIDTH),
    .CNT_W(CNT_W)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .errOut(errOut), .pendDiv(pendDiv), .strb(strb)
  );

  cdiv_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .pendDiv(pendDiv), .strb(strb),
    .tickOut(tickOut), .clkOut(clkOut)
  );

endmodule

// File: rtl/cdiv_checker.sv
module cdiv_checker #(
  parameter bit MASKED_WRITE = 1'b0,
  parameter bit READ_ONLY    = 1'b0,
  parameter int CNT_W        = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [31:0]      rdData,
  input logic             tickOut,
  input logic             clkOut,
  input logic             errOut,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] activeDiv,
  input logic [CNT_W-1:0] pendDiv
);

  assert_count_bound_R11: assert property (@(posedge clk) disable iff (!rstN)
    cnt < activeDiv);

  assert_tick_not_high_R11: assert property (@(posedge clk) disable iff (!rstN)
    tickOut |-> !clkOut);

  assert_reload_boundary_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(activeDiv) |-> $past(tickOut));

  assert_error_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    errOut |-> $stable(pendDiv));

  assert_hold_no_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(rdData));

  generate
    if (READ_ONLY) begin : g_ro
      assert_readonly_R9: assert property (@(posedge clk) disable iff (!rstN)
        rdData == 32'h0);
    end
    if (MASKED_WRITE) begin : g_mask
      assert_mask_upper_R8: assert property (@(posedge clk) disable iff (!rstN)
        rdData[31:16] == 16'h0);
    end
  endgenerate

endmodule

bind clk_ratio_divider cdiv_checker #(
  .MASKED_WRITE(MASKED_WRITE), .READ_ONLY(READ_ONLY), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdData(rdData), .tickOut(tickOut),
  .clkOut(clkOut), .errOut(errOut), .cnt(u_dp.cnt), .activeDiv(u_dp.activeDiv),
  .pendDiv(pendDiv)
);

// File: tb/sim_clk_ratio_divider.sv
`timescale 1ns/1ps
module sim_clk_ratio_divider;
  import cdiv_pkg::*;

  localparam int N = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [N-1:0] tick, sq, err;
  logic [31:0] rd [N];

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  // u0 zero-based, u1 one-based masked, u2 one-based bypass, u3 pow2, u4 max-at-zero, u5 read-only
  clk_ratio_divider u0 (.clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rd[0]),
    .tickOut(tick[0]), .clkOut(sq[0]), .errOut(err[0]));
  clk_ratio_divider #(.DECODE(DEC_ONE_BASED), .MASKED_WRITE(1'b1)) u1 (.clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrData(wrData), .rdData(rd[1]), .tickOut(tick[1]), .clkOut(sq[1]), .errOut(err[1]));
  clk_ratio_divider #(.DECODE(DEC_ONE_BASED), .ALLOW_ZERO(1'b1)) u2 (.clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrData(wrData), .rdData(rd[2]), .tickOut(tick[2]), .clkOut(sq[2]), .errOut(err[2]));
  clk_ratio_divider #(.DECODE(DEC_POW2)) u3 (.clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .rdData(rd[3]), .tickOut(tick[3]), .clkOut(sq[3]), .errOut(err[3]));
  clk_ratio_divider #(.DECODE(DEC_MAX_AT_ZERO)) u4 (.clk(clk), .rstN(rstN), .wrEn(wrEn),
    .wrData(wrData), .rdData(rd[4]), .tickOut(tick[4]), .clkOut(sq[4]), .errOut(err[4]));
  clk_ratio_divider #(.READ_ONLY(1'b1)) u5 (.clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .rdData(rd[5]), .tickOut(tick[5]), .clkOut(sq[5]), .errOut(err[5]));

  // ---------------- scoreboard ----------------
  int    qInst[$];
  int    qPer[$];
  string qTag[$];
  int    since [N];
  int    hiAcc [N];

  initial for (int i = 0; i < N; i++) begin since[i] = 0; hiAcc[i] = 0; end

  always @(negedge clk) begin
    if (rstN) begin
      for (int i = 0; i < N; i++) begin
        if (tick[i]) begin
          int p;
          int h;
          p = since[i] + 1;
          h = hiAcc[i] + int'(sq[i]);
          if (qInst.size() != 0 && qInst[0] == i) begin
            checks++;
            if (p != qPer[0]) begin
              errors++;
              $display("FAIL %s u%0d period actual=%0d expected=%0d", qTag[0], i, p, qPer[0]);
            end
            checks++;
            if (h != qPer[0] / 2) begin
              errors++;
              $display("FAIL R11 u%0d high time actual=%0d expected=%0d", i, h, qPer[0] / 2);
            end
            void'(qInst.pop_front());
            void'(qPer.pop_front());
            void'(qTag.pop_front());
          end
          since[i] = 0;
          hiAcc[i] = 0;
        end else begin
          since[i] = since[i] + 1;
          hiAcc[i] = hiAcc[i] + int'(sq[i]);
        end
      end
    end
  end

  // ---------------- driver ----------------
  task automatic busWrite(input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic settle();
    repeat (150) @(negedge clk);
  endtask

  task automatic expectPeriod(input int inst, input int per, input string tag);
    qInst.push_back(inst);
    qPer.push_back(per);
    qTag.push_back(tag);
    while (qInst.size() != 0) @(negedge clk);
  endtask

  task automatic checkVal(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R1..: actual=hung expected=done");
    finish();
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    settle();

    // reset state
    checkVal(rd[0], 32'h0, "R1 readback after reset");
    checkVal({31'h0, err[1]}, 32'h1, "R3 error flag on zero after reset");
    checkVal({31'h0, err[2]}, 32'h0, "R4 no error with bypass");
    expectPeriod(0, 1, "R1");
    expectPeriod(4, 16, "R1");
    expectPeriod(1, 1, "R3 fallback");

    // field 3 with junk outside the field; mask covers no field bit for u1
    busWrite(32'h5A00_0035);
    settle();
    checkVal(rd[0], 32'h5A00_0035, "R7 full readback");
    checkVal(rd[1], 32'h0, "R8 masked-off bits unchanged");
    checkVal(rd[5], 32'h0, "R9 read-only readback");
    expectPeriod(0, 4, "R2 R7");
    expectPeriod(2, 3, "R3");
    expectPeriod(3, 8, "R5");
    expectPeriod(4, 3, "R6");
    expectPeriod(5, 1, "R9");
    expectPeriod(1, 1, "R8");

    // field 5; u1 mask enables bits 7:4
    busWrite(32'h00F0_0050);
    settle();
    checkVal(rd[1], 32'h0000_0050, "R8 masked write");
    checkVal({31'h0, err[1]}, 32'h0, "R3 error cleared");
    expectPeriod(0, 6, "R2");
    expectPeriod(1, 5, "R3 R8");
    expectPeriod(2, 5, "R3");
    expectPeriod(3, 32, "R5");
    expectPeriod(4, 5, "R6");
    expectPeriod(5, 1, "R9");
    checkVal(rd[5], 32'h0, "R9 read-only after write");

    // field 0 everywhere
    busWrite(32'h00F0_0000);
    settle();
    checkVal({31'h0, err[1]}, 32'h1, "R3 error on invalid zero");
    checkVal({31'h0, err[2]}, 32'h0, "R4 bypass has no error");
    checkVal(rd[1], 32'h0, "R8 masked clear");
    expectPeriod(1, 5, "R3 hold last valid");
    expectPeriod(2, 1, "R4");
    expectPeriod(0, 1, "R2");
    expectPeriod(3, 1, "R5");
    expectPeriod(4, 16, "R6");

    // field 9; no mask bits for u1
    busWrite(32'h0000_0090);
    settle();
    checkVal(rd[1], 32'h0, "R8 no mask no change");
    expectPeriod(1, 5, "R8");
    expectPeriod(0, 10, "R2");

    // mid-period ratio change on u0
    do @(negedge clk); while (!tick[0]);
    repeat (3) @(negedge clk);
    busWrite(32'h0000_0010);
    expectPeriod(0, 10, "R10 old period completes");
    expectPeriod(0, 2, "R10 new period");

    finish();
  end

endmodule